// File: doc/BRIEF.md
# Ramp-Compare Single-Slope Converter Controller

This block drives the digital half of a single-slope analog-to-digital converter. It produces a fixed-frequency pulse train whose high time is set by a duty count. The count goes up by a programmable step at the end of every period. An external RC integrator smooths the pulse train into a slowly rising reference voltage, and external comparators check that voltage against the analog inputs. Each comparator output comes back to the block. When the reference climbs past a channel's input, the block records the duty count at that moment as the channel's conversion result.

A conversion begins with a one-cycle start strobe. The block first holds the pulse output low for a fixed discharge time so that the integrating capacitor can empty. It then sweeps the duty count from its minimum up to its maximum, after which it returns to idle. All channels are converted at the same time against the one shared ramp. The step size trades resolution for conversion time: a step of one gives 8 bits, two gives 7 bits and four gives 6 bits.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is active and after its release, pwm_o is low, every valid_o bit is 0 and every result field is 0.
- R2: A start_i pulse seen in idle holds pwm_o low for DISCH_CYCLES clock cycles. pwm_o then first goes high DISCH_CYCLES+1 cycles after the clock edge that sampled the start.
- R3: A start_i pulse during discharge or during a sweep has no effect on the outputs.
- R4: During a sweep, each PWM period lasts PERIOD cycles. pwm_o is high for the first `count` cycles of each period, delayed by one register stage, and it is low at all other times.
- R5: The duty count of the first period is MIN_CNT (4 by default). At the end of each period it grows by the step.
- R6: The step is taken from res_sel_i on the start edge and is held for the whole sweep. The encoding is 2'b00 for step 1, 2'b01 for step 2, and 2'b10 or 2'b11 for step 4.
- R7: The sweep ends with the period whose count plus step would exceed MAX_CNT (240 by default). By default this gives 237, 119 and 60 periods for steps 1, 2 and 4. The block then returns to idle with pwm_o low.
- R8: Each cmp_i bit passes through a two-flop synchroniser. A rising edge of the synchronised bit during a sweep stores the current duty count in that channel's result field and sets its valid bit. Only the first rising edge in a sweep is stored.
- R9: The channels capture independently. Result field c is result_o[c*CNT_W +: CNT_W].
- R10: A channel with no trip during a sweep reports MAX_CNT, and its valid bit is set at the end of the sweep.
- R11: Comparator edges outside a sweep (in idle or during discharge) leave results and valid bits unchanged.
- R12: All valid bits clear on the clock edge at which a sweep begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion start strobe |
| res_sel_i | input | 2 | Step (resolution) select, sampled at start |
| cmp_i | input | N_CH | Comparator outputs, asynchronous |
| pwm_o | output | 1 | PWM drive to the external integrator |
| result_o | output | N_CH*CNT_W | Per-channel captured duty counts |
| valid_o | output | N_CH | Per-channel result valid flags |

## Verification
The bench builds the block with PERIOD=242 and DISCH_CYCLES=16 and keeps the default 4-to-240 count range and two channels. Because the period is only two cycles longer than the maximum count, complete sweeps at all three step sizes fit in a short run, and the final 240-count period still shows a low gap in each cycle. The short discharge window leaves room to place a comparator edge fully inside discharge and then confirm the flag clear at sweep entry a few cycles later.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DISCH = 2'd1,
      ST_SWEEP = 2'd2
   } seq_state_t;

   localparam int STEP_W = 3;

   // Step encoding: 00 -> 1, 01 -> 2, 10/11 -> 4
   function automatic logic [STEP_W-1:0] step_of(input logic [1:0] sel);
      logic [STEP_W-1:0] s;
      case (sel)
         2'b00:   s = 3'd1;
         2'b01:   s = 3'd2;
         default: s = 3'd4;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ramp_cmp_sync.sv
module ramp_cmp_sync #(
   parameter int N_CH   = 2,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] cmp_i,
   output logic [N_CH-1:0] rise_o
);

   initial begin
      assert (STAGES >= 2) else $error("ramp_cmp_sync: STAGES must be at least 2");
      assert (N_CH >= 1)   else $error("ramp_cmp_sync: N_CH must be at least 1");
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], cmp_i[c]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign rise_o[c] = chain_q[STAGES-1] & ~prev_q;

      if (STAGES == 2) begin : g_chk2
         AST_RISE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[c] |-> $past(cmp_i[c], 2)); // R8
      end
   end

endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
   import ramp_adc_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int MIN_CNT      = 4,
   parameter int MAX_CNT      = 240,
   parameter int PERIOD       = 256,
   parameter int DISCH_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       res_sel_i,
   output logic             pwm_o,
   output logic [CNT_W-1:0] count_o,
   output logic             sweep_o,
   output logic             sweep_begin_o,
   output logic             sweep_end_o
);

   localparam int PH_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam int DLY_W = (DISCH_CYCLES > 2) ? $clog2(DISCH_CYCLES) : 1;
   localparam int CMP_W = (PH_W > CNT_W) ? PH_W : CNT_W;
   localparam int SUM_W = CNT_W + 1;

   initial begin
      assert (CNT_W >= 3)               else $error("ramp_sequencer: CNT_W too small");
      assert (MIN_CNT >= 1)             else $error("ramp_sequencer: MIN_CNT must be positive");
      assert (MIN_CNT <= MAX_CNT)       else $error("ramp_sequencer: MIN_CNT above MAX_CNT");
      assert (MAX_CNT < (1 << CNT_W))   else $error("ramp_sequencer: MAX_CNT does not fit CNT_W");
      assert (PERIOD > MAX_CNT)         else $error("ramp_sequencer: PERIOD must exceed MAX_CNT");
      assert (DISCH_CYCLES >= 1)        else $error("ramp_sequencer: DISCH_CYCLES must be at least 1");
   end

   seq_state_t        st_q;
   logic [PH_W-1:0]   ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step_q;
   logic [DLY_W-1:0]  dly_q;
   logic              pwm_q;

   logic [SUM_W-1:0]  nxt_sum;
   logic              period_last;
   logic              disch_last;
   logic              last_period;
   logic              high_phase;

   always_comb begin
      nxt_sum     = {1'b0, cnt_q} + SUM_W'(step_q);
      period_last = (ph_q == PH_W'(PERIOD - 1));
      disch_last  = (dly_q == DLY_W'(DISCH_CYCLES - 1));
      last_period = (nxt_sum > SUM_W'(MAX_CNT));
      high_phase  = (CMP_W'(ph_q) < CMP_W'(cnt_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= '0;
         cnt_q  <= CNT_W'(MIN_CNT);
         step_q <= STEP_W'(1);
         dly_q  <= '0;
         pwm_q  <= 1'b0;
      end else begin
         pwm_q <= (st_q == ST_SWEEP) && high_phase;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_DISCH;
                  dly_q  <= '0;
                  step_q <= step_of(res_sel_i);
                  cnt_q  <= CNT_W'(MIN_CNT);
               end
            end
            ST_DISCH: begin
               if (disch_last) begin
                  st_q <= ST_SWEEP;
                  ph_q <= '0;
               end else begin
                  dly_q <= dly_q + 1'b1;
               end
            end
            ST_SWEEP: begin
               if (period_last) begin
                  ph_q <= '0;
                  if (last_period) begin
                     st_q  <= ST_IDLE;
                     cnt_q <= CNT_W'(MIN_CNT);
                  end else begin
                     cnt_q <= nxt_sum[CNT_W-1:0];
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign pwm_o         = pwm_q;
   assign count_o       = cnt_q;
   assign sweep_o       = (st_q == ST_SWEEP);
   assign sweep_begin_o = (st_q == ST_DISCH) && disch_last;
   assign sweep_end_o   = (st_q == ST_SWEEP) && period_last && last_period;

   AST_PWM_ONLY_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_q |-> $past(st_q) == ST_SWEEP); // R4
   AST_DISCH_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DISCH) |=> !pwm_q); // R2
   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= CNT_W'(MIN_CNT)) && (cnt_q <= CNT_W'(MAX_CNT))); // R5
   AST_COUNT_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SWEEP) && !period_last |=> $stable(cnt_q)); // R5
   AST_STEP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(step_q)); // R3
   AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_end_o |=> (st_q == ST_IDLE) && (cnt_q == CNT_W'(MIN_CNT))); // R7

endmodule

// File: rtl/ramp_chan_capture.sv
module ramp_chan_capture #(
   parameter int CNT_W   = 8,
   parameter int MAX_CNT = 240
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             sweep_i,
   input  logic             sweep_begin_i,
   input  logic             sweep_end_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] result_o,
   output logic             valid_o
);

   logic [CNT_W-1:0] res_q;
   logic             vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else if (sweep_begin_i) begin
         vld_q <= 1'b0;
      end else if (sweep_i && !vld_q) begin
         if (rise_i) begin
            res_q <= count_i;
            vld_q <= 1'b1;
         end else if (sweep_end_i) begin
            res_q <= CNT_W'(MAX_CNT);
            vld_q <= 1'b1;
         end
      end
   end

   assign result_o = res_q;
   assign valid_o  = vld_q;

   AST_FIRST_TRIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !sweep_begin_i |=> valid_o && $stable(result_o)); // R8
   AST_NO_CAPTURE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !sweep_i |=> $stable(result_o)); // R11
   AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_end_i |=> valid_o); // R10
   AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_begin_i |=> !valid_o); // R12

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
   parameter int N_CH         = 2,
   parameter int CNT_W        = 8,
   parameter int MIN_CNT      = 4,
   parameter int MAX_CNT      = 240,
   parameter int PERIOD       = 256,
   parameter int DISCH_CYCLES = 64,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [1:0]            res_sel_i,
   input  logic [N_CH-1:0]       cmp_i,
   output logic                  pwm_o,
   output logic [N_CH*CNT_W-1:0] result_o,
   output logic [N_CH-1:0]       valid_o
);

   initial begin
      assert (N_CH >= 1 && N_CH <= 16) else $error("ramp_adc_ctrl: N_CH out of range");
   end

   logic [N_CH-1:0]  rise;
   logic [CNT_W-1:0] count;
   logic             sweep;
   logic             sweep_begin;
   logic             sweep_end;

   ramp_cmp_sync #(
      .N_CH   (N_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmp_i  (cmp_i),
      .rise_o (rise)
   );

   ramp_sequencer #(
      .CNT_W        (CNT_W),
      .MIN_CNT      (MIN_CNT),
      .MAX_CNT      (MAX_CNT),
      .PERIOD       (PERIOD),
      .DISCH_CYCLES (DISCH_CYCLES)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .res_sel_i     (res_sel_i),
      .pwm_o         (pwm_o),
      .count_o       (count),
      .sweep_o       (sweep),
      .sweep_begin_o (sweep_begin),
      .sweep_end_o   (sweep_end)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_cap
      ramp_chan_capture #(
         .CNT_W   (CNT_W),
         .MAX_CNT (MAX_CNT)
      ) u_cap (
         .clk           (clk),
         .rst_n         (rst_n),
         .rise_i        (rise[c]),
         .sweep_i       (sweep),
         .sweep_begin_i (sweep_begin),
         .sweep_end_i   (sweep_end),
         .count_i       (count),
         .result_o      (result_o[c*CNT_W +: CNT_W]),
         .valid_o       (valid_o[c])
      );
   end

   AST_PWM_LOW_IN_RESET: assert property (@(posedge clk)
      !rst_n |=> !pwm_o || rst_n); // R1

endmodule

// File: tb/tb_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module tb_ramp_adc_ctrl;

   localparam int P    = 242;
   localparam int D    = 16;
   localparam int MINC = 4;
   localparam int MAXC = 240;
   localparam int W    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] res_sel_i = 2'b00;
   logic [1:0] cmp_i = 2'b00;
   logic       pwm_o;
   logic [2*W-1:0] result_o;
   logic [1:0] valid_o;

   ramp_adc_ctrl #(
      .N_CH(2), .CNT_W(W), .MIN_CNT(MINC), .MAX_CNT(MAXC),
      .PERIOD(P), .DISCH_CYCLES(D), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .res_sel_i(res_sel_i),
      .cmp_i(cmp_i), .pwm_o(pwm_o), .result_o(result_o), .valid_o(valid_o)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_start = 0;
   int first_hi = -1;
   bit armed = 1'b0;
   int edges = 0;
   bit pwm_prev = 1'b0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_st = 0, m_dly = 0, m_ph = 0, m_cnt = MINC, m_step = 1, m_pwm = 0;
   int m_res[2];
   bit m_vld[2];
   bit [1:0] m_s1 = 0, m_s2 = 0, m_s3 = 0, m_rise;
   bit m_end, m_beg;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int res_of(input int c);
      return int'(result_o[c*W +: W]);
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_st = 0; m_dly = 0; m_ph = 0; m_cnt = MINC; m_step = 1; m_pwm = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
         for (int c = 0; c < 2; c++) begin m_res[c] = 0; m_vld[c] = 0; end
      end else begin
         m_rise = m_s2 & ~m_s3;
         m_end  = (m_st == 2) && (m_ph == P-1) && (m_cnt + m_step > MAXC);
         m_beg  = (m_st == 1) && (m_dly == D-1);
         for (int c = 0; c < 2; c++) begin
            if (m_beg) m_vld[c] = 0;
            else if (m_st == 2 && !m_vld[c]) begin
               if (m_rise[c]) begin m_res[c] = m_cnt; m_vld[c] = 1; end
               else if (m_end) begin m_res[c] = MAXC; m_vld[c] = 1; end
            end
         end
         m_pwm = (m_st == 2 && m_ph < m_cnt) ? 1 : 0;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = cmp_i;
         case (m_st)
            0: if (start_i) begin
                  m_st = 1; m_dly = 0; m_cnt = MINC;
                  m_step = (res_sel_i == 2'b00) ? 1 : (res_sel_i == 2'b01) ? 2 : 4;
               end
            1: if (m_dly == D-1) begin m_st = 2; m_ph = 0; end
               else m_dly++;
            2: if (m_ph == P-1) begin
                  m_ph = 0;
                  if (m_end) begin m_st = 0; m_cnt = MINC; end
                  else m_cnt += m_step;
               end else m_ph++;
            default: m_st = 0;
         endcase
      end
   end

   // per-cycle comparison and monitors
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(pwm_o == m_pwm[0], "R4", "pwm", int'(pwm_o), m_pwm);
         for (int c = 0; c < 2; c++) begin
            chk(valid_o[c] == m_vld[c], "R12", "valid", int'(valid_o[c]), int'(m_vld[c]));
            chk(res_of(c) == m_res[c], "R8", "result", res_of(c), m_res[c]);
         end
         if (pwm_o && !pwm_prev) edges++;
         if (armed && pwm_o) begin first_hi = cyc; armed = 1'b0; end
         pwm_prev = pwm_o;
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic go(input logic [1:0] sel);
      @(negedge clk);
      res_sel_i = sel; start_i = 1'b1; edges = 0; armed = 1'b1; first_hi = -1;
      @(negedge clk);
      start_i = 1'b0;
      t_start = cyc;
   endtask

   task automatic at(input int n);
      while (cyc < t_start + n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(pwm_o == 1'b0, "R1", "pwm in reset", int'(pwm_o), 0);
      chk(valid_o == 2'b00, "R1", "valid in reset", int'(valid_o), 0);
      chk(result_o == '0, "R1", "result in reset", int'(result_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pwm_o == 1'b0 && valid_o == 2'b00, "R1", "idle after reset", int'(pwm_o), 0);

      // sweep A: step 1
      go(2'b00);
      at(D + 96*P + 10);  cmp_i[0] = 1'b1;
      at(D + 96*P + 20);
      chk(res_of(0) == 100, "R8", "ch0 capture", res_of(0), 100);
      chk(valid_o[0] == 1'b1, "R8", "ch0 valid", int'(valid_o[0]), 1);
      at(D + 120*P + 5);  start_i = 1'b1;   // R3: ignored while busy
      @(negedge clk);     start_i = 1'b0;
      at(D + 130*P);      cmp_i[0] = 1'b0;
      at(D + 150*P + 10); cmp_i[0] = 1'b1;  // second trip, ignored
      at(D + 200*P + 10); cmp_i[1] = 1'b1;
      at(D + 237*P + 4);
      chk(first_hi - t_start == D + 1, "R2", "first pwm high", first_hi - t_start, D + 1);
      chk(edges == 237, "R5", "periods step1", edges, 237);
      chk(edges == 237, "R3", "busy start ignored", edges, 237);
      chk(res_of(0) == 100, "R8", "ch0 first trip kept", res_of(0), 100);
      chk(res_of(1) == 204, "R9", "ch1 capture", res_of(1), 204);
      chk(valid_o == 2'b11, "R9", "both valid", int'(valid_o), 3);
      chk(pwm_o == 1'b0, "R7", "pwm low after sweep", int'(pwm_o), 0);

      // idle trip ignored
      cmp_i = 2'b00;
      repeat (3) @(negedge clk);
      cmp_i[0] = 1'b1;
      repeat (6) @(negedge clk);
      chk(res_of(0) == 100, "R11", "idle trip ignored", res_of(0), 100);
      cmp_i[0] = 1'b0;
      repeat (3) @(negedge clk);

      // sweep B: step 2
      go(2'b01);
      at(2); cmp_i[1] = 1'b1;               // edge during discharge
      at(D - 1);
      chk(res_of(1) == 204, "R11", "discharge trip ignored", res_of(1), 204);
      chk(valid_o[1] == 1'b1, "R11", "valid kept in discharge", int'(valid_o[1]), 1);
      at(D);
      chk(valid_o == 2'b00, "R12", "valid cleared at sweep entry", int'(valid_o), 0);
      at(D + 50*P + 10); cmp_i[0] = 1'b1;
      at(D + 119*P + 4);
      chk(edges == 119, "R6", "periods step2", edges, 119);
      chk(res_of(0) == 104, "R5", "ch0 step2 capture", res_of(0), 104);
      chk(res_of(1) == MAXC, "R10", "ch1 full scale", res_of(1), MAXC);
      chk(valid_o == 2'b11, "R10", "valid at end", int'(valid_o), 3);
      cmp_i = 2'b00;
      repeat (3) @(negedge clk);

      // sweep C: step 4, select changed mid-sweep
      go(2'b10);
      at(5); res_sel_i = 2'b00;
      at(D + 10*P + 10); cmp_i[1] = 1'b1;
      at(D + 60*P + 4);
      chk(edges == 60, "R6", "periods step4", edges, 60);
      chk(res_of(1) == 44, "R6", "ch1 step4 capture", res_of(1), 44);
      chk(res_of(0) == MAXC, "R10", "ch0 full scale", res_of(0), MAXC);
      cmp_i = 2'b00;
      repeat (3) @(negedge clk);

      // sweep D: code 2'b11 also step 4
      go(2'b11);
      at(D + 60*P + 4);
      chk(edges == 60, "R7", "periods code 11", edges, 60);
      chk(res_of(0) == MAXC && res_of(1) == MAXC, "R10", "no trips", res_of(0), MAXC);
      chk(pwm_o == 1'b0, "R7", "idle pwm", int'(pwm_o), 0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule